// File: doc/BRIEF.md
# Hot-swap power-up sequencer

This block steps a hot-swap slot through power-up. While the slot is idle, it waits until three inputs are all true: the pin-detect enable, the undervoltage-valid input and the overvoltage-valid input. When they are, it waits out a programmable pin-detect delay and then raises the gate enable. It then watches how long the slot stays in current regulation. After the FET reports fully on, it releases the first power-good output. Once the feedback input goes high, it releases the second power-good output.

Each of the four delays is set by a 4-bit code. The code selects one of sixteen fixed, nonlinear durations. Time is counted in ticks of 0.25 ms, and each tick is a one-cycle pulse on the tick-enable input. The two 8-bit configuration words are plain inputs. They are captured when the sequencer leaves idle, so rewriting them during a power-up attempt has no effect on that attempt.

If the slot is still in regulation when the start-up regulation limit runs out, the sequencer latches a fault. It then holds every drive output low until a restart request arrives.

Top module: `hs_power_sequencer`

## Requirements
- R1: A 4-bit timer code k selects a length in ticks. Code 0 gives 1 tick and code 1 gives 8. For k of 2 and above, an even k gives 2·2^(k/2+3) ticks and an odd k gives 3·2^((k-1)/2+3) ticks. The full set is 32, 48, 64, 96, 128, 192, 256, 384, 512, 768, 1024, 1536, 2048 and 3072.
- R2: After reset, gate_en, pgood0, pgood1 and fault_flag are all low.
- R3: The pin-detect delay uses cfg_a bits [3:0]. It starts when pd_en, uv_ok and ov_ok are all high. gate_en rises exactly that many ticks later. The qualification is seen at one edge, so gate_en is high after edge 1+T. If any of the three inputs stays low, gate_en stays low.
- R4: While gate_en is high and before the FET reports fully on, the gate stays up and the outputs pgood0 and pgood1 stay low.
- R5: The regulation limit uses cfg_a bits [7:4] and counts from the rise of gate_en. If in_reg is high on a tick once the limit has elapsed, the sequencer enters fault on that edge. In fault, fault_flag is high and gate_en, pgood0 and pgood1 are low.
- R6: Slot 0 uses cfg_b bits [3:0]. A high fet_on during regulation is seen at one edge. pgood0 rises slot-0 ticks after that edge.
- R7: Slot 1 uses cfg_b bits [7:4]. After pgood0 is high, a high fb_high is seen at one edge. pgood1 rises slot-1 ticks after that edge. pgood1 is never high while pgood0 is low.
- R8: Outside fault, if pd_en, uv_ok or ov_ok goes low, the next edge drops every output and clears the timer.
- R9: fault_flag stays high until restart is seen at an edge. Restart returns the sequencer to idle, even while qualification is lost.
- R10: The configuration words are captured when the sequencer leaves idle. Later changes do not affect that attempt.
- R11: The timer advances only on cycles where tick_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One 0.25 ms time-base tick per high cycle |
| cfg_a | input | 8 | [7:4] regulation limit code, [3:0] pin-detect delay code |
| cfg_b | input | 8 | [7:4] slot 1 code, [3:0] slot 0 code |
| pd_en | input | 1 | Pin detect enabled |
| uv_ok | input | 1 | Undervoltage condition valid |
| ov_ok | input | 1 | Overvoltage condition valid |
| in_reg | input | 1 | Current regulation active |
| fet_on | input | 1 | Pass FET fully on |
| fb_high | input | 1 | Feedback input high |
| restart | input | 1 | Leave the fault state |
| gate_en | output | 1 | Gate drive enable |
| pgood0 | output | 1 | First power-good output |
| pgood1 | output | 1 | Second power-good output |
| fault_flag | output | 1 | Sticky start-up regulation fault |

## Verification
The bench builds the block with its default 12-bit counter and holds the tick high on every cycle. This makes the longest code, 3072 ticks, short enough to sweep in full. All sixteen codes are run through every phase: pin-detect delay, regulation fault, slot 0 and slot 1. Each measured edge count is compared with the table computed from the R1 formula. The separate runs that gate the tick, rewrite the configuration mid-attempt and withhold one qualifier are only possible because each phase's cycle count is known exactly.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDLY,
        ST_RAMP,
        ST_SLOT0,
        ST_FBWAIT,
        ST_SLOT1,
        ST_UP,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [CODE_W-1:0]   c_pd;
        logic [CODE_W-1:0]   c_reg;
        logic [CODE_W-1:0]   c_s0;
        logic [CODE_W-1:0]   c_s1;
    } seq_regs_t;

endpackage

// File: rtl/hs_code_lut.sv
module hs_code_lut
    import hs_seq_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  term_o
);

    always_comb begin
        case (code_i)
            4'd0:    term_o = CNT_W'(1);
            4'd1:    term_o = CNT_W'(8);
            4'd2:    term_o = CNT_W'(32);
            4'd3:    term_o = CNT_W'(48);
            4'd4:    term_o = CNT_W'(64);
            4'd5:    term_o = CNT_W'(96);
            4'd6:    term_o = CNT_W'(128);
            4'd7:    term_o = CNT_W'(192);
            4'd8:    term_o = CNT_W'(256);
            4'd9:    term_o = CNT_W'(384);
            4'd10:   term_o = CNT_W'(512);
            4'd11:   term_o = CNT_W'(768);
            4'd12:   term_o = CNT_W'(1024);
            4'd13:   term_o = CNT_W'(1536);
            4'd14:   term_o = CNT_W'(2048);
            default: term_o = CNT_W'(3072);
        endcase
    end

endmodule

// File: rtl/hs_phase_timer.sv
module hs_phase_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    assign at_end   = (cnt_q == term_i - ONE);
    assign expire_o = tick_i && at_end;

    // Saturates at term-1 so expiry repeats on every later tick.
    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && !at_end) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (cnt_q < term_i));

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_a,
    input  logic [7:0]        cfg_b,
    input  logic              pd_en,
    input  logic              uv_ok,
    input  logic              ov_ok,
    input  logic              in_reg,
    input  logic              fet_on,
    input  logic              fb_high,
    input  logic              restart,
    input  logic              expire_i,
    output logic [CODE_W-1:0] code_o,
    output logic              tclear_o,
    output logic              gate_o,
    output logic              pg0_o,
    output logic              pg1_o,
    output logic              fault_o
);

    seq_regs_t r_d, r_q;
    logic      qual;
    logic      timed;

    assign qual = pd_en && uv_ok && ov_ok;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (qual) begin
                    r_d.st    = ST_PDLY;
                    r_d.c_pd  = cfg_a[3:0];
                    r_d.c_reg = cfg_a[7:4];
                    r_d.c_s0  = cfg_b[3:0];
                    r_d.c_s1  = cfg_b[7:4];
                end
            end
            ST_PDLY:   if (expire_i) r_d.st = ST_RAMP;
            ST_RAMP: begin
                if (expire_i && in_reg) r_d.st = ST_FAULT;
                else if (fet_on)        r_d.st = ST_SLOT0;
            end
            ST_SLOT0:  if (expire_i) r_d.st = ST_FBWAIT;
            ST_FBWAIT: if (fb_high)  r_d.st = ST_SLOT1;
            ST_SLOT1:  if (expire_i) r_d.st = ST_UP;
            ST_UP:     r_d.st = ST_UP;
            ST_FAULT:  if (restart)  r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
        if (!qual && r_q.st != ST_FAULT) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, c_pd: '0, c_reg: '0, c_s0: '0, c_s1: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            ST_PDLY:  code_o = r_q.c_pd;
            ST_RAMP:  code_o = r_q.c_reg;
            ST_SLOT0: code_o = r_q.c_s0;
            ST_SLOT1: code_o = r_q.c_s1;
            default:  code_o = '0;
        endcase
    end

    assign timed    = (r_q.st == ST_PDLY) || (r_q.st == ST_RAMP) ||
                      (r_q.st == ST_SLOT0) || (r_q.st == ST_SLOT1);
    assign tclear_o = (r_d.st != r_q.st) || !timed;

    assign gate_o  = (r_q.st == ST_RAMP) || (r_q.st == ST_SLOT0) ||
                     (r_q.st == ST_FBWAIT) || (r_q.st == ST_SLOT1) ||
                     (r_q.st == ST_UP);
    assign pg0_o   = (r_q.st == ST_FBWAIT) || (r_q.st == ST_SLOT1) ||
                     (r_q.st == ST_UP);
    assign pg1_o   = (r_q.st == ST_UP);
    assign fault_o = (r_q.st == ST_FAULT);

    // R8
    qual_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> (!gate_o && !pg0_o && !pg1_o));

    // R3
    gate_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(qual));

    // R5
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!gate_o && !pg0_o && !pg1_o));

    // R7
    pg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg1_o |-> pg0_o);

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !restart) |=> fault_o);

    // R6
    pg0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg0_o) |-> gate_o);

endmodule

// File: rtl/hs_power_sequencer.sv
module hs_power_sequencer
    import hs_seq_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [7:0] cfg_a,
    input  logic [7:0] cfg_b,
    input  logic       pd_en,
    input  logic       uv_ok,
    input  logic       ov_ok,
    input  logic       in_reg,
    input  logic       fet_on,
    input  logic       fb_high,
    input  logic       restart,
    output logic       gate_en,
    output logic       pgood0,
    output logic       pgood1,
    output logic       fault_flag
);

    logic [CODE_W-1:0] sel_code;
    logic [CNT_W-1:0]  term;
    logic              tclear;
    logic              expire;

    hs_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_a    (cfg_a),
        .cfg_b    (cfg_b),
        .pd_en    (pd_en),
        .uv_ok    (uv_ok),
        .ov_ok    (ov_ok),
        .in_reg   (in_reg),
        .fet_on   (fet_on),
        .fb_high  (fb_high),
        .restart  (restart),
        .expire_i (expire),
        .code_o   (sel_code),
        .tclear_o (tclear),
        .gate_o   (gate_en),
        .pg0_o    (pgood0),
        .pg1_o    (pgood1),
        .fault_o  (fault_flag)
    );

    hs_code_lut #(.CNT_W(CNT_W)) u_lut (
        .code_i (sel_code),
        .term_o (term)
    );

    hs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (tclear),
        .tick_i   (tick_en),
        .term_i   (term),
        .expire_o (expire)
    );

endmodule

// File: tb/hs_power_sequencer_test.sv
module hs_power_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [7:0] cfg_a = '0;
    logic [7:0] cfg_b = '0;
    logic       pd_en = 1'b0, uv_ok = 1'b0, ov_ok = 1'b0;
    logic       in_reg = 1'b0, fet_on = 1'b0, fb_high = 1'b0, restart = 1'b0;
    logic       gate_en, pgood0, pgood1, fault_flag;

    int checks = 0;
    int fails  = 0;
    int n;

    always #4 clk = ~clk;

    hs_power_sequencer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .pd_en(pd_en), .uv_ok(uv_ok), .ov_ok(ov_ok), .in_reg(in_reg),
        .fet_on(fet_on), .fb_high(fb_high), .restart(restart),
        .gate_en(gate_en), .pgood0(pgood0), .pgood1(pgood1), .fault_flag(fault_flag)
    );

    function automatic int ticks_of(input int c);
        if (c == 0) return 1;
        if (c == 1) return 8;
        return ((c % 2 == 0) ? 2 : 3) << (c / 2 + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // which: 0 gate_en, 1 pgood0, 2 pgood1, 3 fault_flag
    task automatic edges_until(input int which, output int cnt);
        logic v;
        cnt = 0;
        v = 1'b0;
        while (!v && cnt < 4000) begin
            step();
            cnt++;
            case (which)
                0: v = gate_en;
                1: v = pgood0;
                2: v = pgood1;
                default: v = fault_flag;
            endcase
        end
    endtask

    task automatic qualify(input logic on);
        pd_en = on; uv_ok = on; ov_ok = on;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        #1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R2 reset state
        chk(!gate_en && !pgood0 && !pgood1 && !fault_flag, "R2 reset",
            {gate_en, pgood0, pgood1, fault_flag}, 0);

        // R3 one qualifier missing keeps the gate off
        cfg_a = 8'h00; pd_en = 1'b1; uv_ok = 1'b1; ov_ok = 1'b0;
        repeat (50) step();
        chk(!gate_en, "R3 partial qualify", gate_en, 0);
        qualify(1'b0);
        step();

        for (int c = 0; c < 16; c++) begin
            int t;
            t = ticks_of(c);
            cfg_a = {4'(c), 4'(c)};
            cfg_b = {4'(c), 4'(c)};
            in_reg = 1'b0; fet_on = 1'b0; fb_high = 1'b0;
            qualify(1'b1);
            edges_until(0, n);
            chk(n == t + 1, "R1 R3 pin-detect delay", n, t + 1);
            chk(!pgood0 && !pgood1, "R4 pgood low before fet", {pgood0, pgood1}, 0);
            fet_on = 1'b1;
            edges_until(1, n);
            chk(n == t + 1, "R6 slot0", n, t + 1);
            chk(!pgood1, "R7 pgood1 waits", pgood1, 0);
            fb_high = 1'b1;
            edges_until(2, n);
            chk(n == t + 1, "R7 slot1", n, t + 1);
            uv_ok = 1'b0;
            step();
            chk(!gate_en && !pgood0 && !pgood1, "R8 qualify lost",
                {gate_en, pgood0, pgood1}, 0);
            fet_on = 1'b0; fb_high = 1'b0;
            step();

            // R5 regulation limit fault
            in_reg = 1'b1;
            uv_ok = 1'b1;
            edges_until(0, n);
            edges_until(3, n);
            chk(n == t, "R5 regulation limit", n, t);
            chk(!gate_en && !pgood0 && !pgood1, "R5 outputs off in fault",
                {gate_en, pgood0, pgood1}, 0);
            uv_ok = 1'b0;
            repeat (2) step();
            chk(fault_flag, "R9 fault sticky", fault_flag, 1);
            restart = 1'b1;
            step();
            restart = 1'b0;
            in_reg = 1'b0;
            chk(!fault_flag, "R9 restart clears", fault_flag, 0);
            step();
        end

        // R10 configuration held after leaving idle
        cfg_a = 8'h05;
        qualify(1'b1);
        step();
        step();
        cfg_a = 8'h00;
        edges_until(0, n);
        chk(n + 2 == ticks_of(5) + 1, "R10 config latched", n + 2, ticks_of(5) + 1);
        qualify(1'b0);
        step();

        // R11 timer runs only on ticks
        cfg_a = 8'h02;
        tick_en = 1'b0;
        qualify(1'b1);
        repeat (40) step();
        chk(!gate_en, "R11 no ticks no progress", gate_en, 0);
        tick_en = 1'b1;
        edges_until(0, n);
        chk(n == ticks_of(2), "R11 delay after ticks resume", n, ticks_of(2));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule